// File: doc/BRIEF.md
# Double-Data-Rate I/O Register Cell

This cell sits between core logic and a pad buffer and moves data at two bits per clock period per lane. On the receive side, two registers capture the pad value. One captures on the rising edge of the input clock and the other on the falling edge. On the transmit side, two data registers are loaded on opposite edges of the output clock. A multiplexer then presents them to the pad, one per clock half. The drive enable for the pad buffer follows the same structure: its own register pair, loaded on both output clock edges and multiplexed in the same way. When the enable is low, the pad buffer is high impedance. The receive registers keep sampling the pad regardless of the enable.

The receive side and the transmit side each have their own clock and their own clock enable. One reset input and one set input act on all six register groups. Reset clears the registers and set fills them with ones, and reset wins when both are high. The parameter `ASYNC_SR` chooses between two ways of applying them. With the value 1 they act immediately. With the value 0 each register applies them on its own active clock edge. `WIDTH` sets the number of parallel lanes.

Top module: `ddr_io_cell`

## Requirements
- R1: When `ice` is high, `in_rise` takes the value `pad_i` had at the rising edge of `ick`.
- R2: When `ice` is high, `in_fall` takes the value `pad_i` had at the falling edge of `ick`.
- R3: While `ock` is high, `pad_o` shows the transmit register loaded from `od_rise` at the rising edge of `ock`. While `ock` is low, it shows the register loaded from `od_fall` at the falling edge.
- R4: `pad_oe` is built from `oe_rise` and `oe_fall` in the same way as `pad_o`. A value of 1 means drive and 0 means high impedance. While `pad_oe` is 0, the receive registers still capture `pad_i`.
- R5: While `ice` is low at an `ick` edge, the receive register for that edge keeps its value.
- R6: While `oce` is low at an `ock` edge, the data and enable registers for that edge keep their values.
- R7: Reset forces every register in the cell to all zeros. `in_rise`, `in_fall`, `pad_o` and `pad_oe` then read 0.
- R8: Set with reset low forces every register in the cell to all ones.
- R9: When reset and set are both high, reset wins and every register reads 0.
- R10: With `ASYNC_SR`=1, set and reset take effect without waiting for a clock edge. With `ASYNC_SR`=0, each register applies them only at its own active clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ick | input | 1 | Receive clock; rising and falling edges both capture |
| ice | input | 1 | Receive clock enable |
| ock | input | 1 | Transmit clock; also the output multiplexer select |
| oce | input | 1 | Transmit clock enable, shared by data and drive-enable registers |
| rst | input | 1 | Reset for all registers, active high, priority over set |
| set | input | 1 | Set for all registers, active high |
| pad_i | input | WIDTH | Value seen at the pad |
| od_rise | input | WIDTH | Transmit data for the high half of `ock` |
| od_fall | input | WIDTH | Transmit data for the low half of `ock` |
| oe_rise | input | WIDTH | Drive enable for the high half of `ock` |
| oe_fall | input | WIDTH | Drive enable for the low half of `ock` |
| in_rise | output | WIDTH | Pad value captured on the rising `ick` edge |
| in_fall | output | WIDTH | Pad value captured on the falling `ick` edge |
| pad_o | output | WIDTH | Multiplexed data to the pad driver |
| pad_oe | output | WIDTH | Multiplexed drive enable; 0 puts the pad in high impedance |

## Verification
The properties assume the following about the control inputs. `ice`, `oce`, `rst` and `set` change only after a falling clock edge and before the next rising edge, and each value lasts at least one full period. So a control value is the same at both edges of a cycle. The properties also assume that `ick` and `ock` are in phase, so a rising `ick` edge finds the multiplexers on their low-half registers. The stimulus keeps to these assumptions. It drives both clocks from one source and changes the controls only a quarter period after a falling edge. Data inputs change at both quarter points, so any value may appear at either edge.

// File: rtl/ddr_io_cell.sv
module ddr_io_cell #(
  parameter int WIDTH    = 1,
  parameter bit ASYNC_SR = 1'b1
) (
  input  logic             ick,
  input  logic             ice,
  input  logic             ock,
  input  logic             oce,
  input  logic             rst,
  input  logic             set,
  input  logic [WIDTH-1:0] pad_i,
  input  logic [WIDTH-1:0] od_rise,
  input  logic [WIDTH-1:0] od_fall,
  input  logic [WIDTH-1:0] oe_rise,
  input  logic [WIDTH-1:0] oe_fall,
  output logic [WIDTH-1:0] in_rise,
  output logic [WIDTH-1:0] in_fall,
  output logic [WIDTH-1:0] pad_o,
  output logic [WIDTH-1:0] pad_oe
);

  localparam int NREG = 6;

  // slot order: in rise, in fall, data rise, data fall, enable rise, enable fall
  logic [NREG-1:0]  clk_v;
  logic [NREG-1:0]  en_v;
  logic [WIDTH-1:0] d_v [NREG];
  logic [WIDTH-1:0] q_v [NREG];

  assign clk_v = {~ock, ock, ~ock, ock, ~ick, ick};
  assign en_v  = {oce, oce, oce, oce, ice, ice};

  assign d_v[0] = pad_i;
  assign d_v[1] = pad_i;
  assign d_v[2] = od_rise;
  assign d_v[3] = od_fall;
  assign d_v[4] = oe_rise;
  assign d_v[5] = oe_fall;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [WIDTH-1:0] r;
    if (ASYNC_SR) begin : g_async
      always_ff @(posedge clk_v[i] or posedge rst or posedge set) begin
        if (rst)        r <= '0;
        else if (set)   r <= '1;
        else if (en_v[i]) r <= d_v[i];
      end
    end else begin : g_sync
      always_ff @(posedge clk_v[i]) begin
        if (rst)        r <= '0;
        else if (set)   r <= '1;
        else if (en_v[i]) r <= d_v[i];
      end
    end
    assign q_v[i] = r;
  end

  assign in_rise = q_v[0];
  assign in_fall = q_v[1];
  assign pad_o   = ock ? q_v[2] : q_v[3];
  assign pad_oe  = ock ? q_v[4] : q_v[5];

endmodule

// File: rtl/ddr_io_cell_chk.sv
module ddr_io_cell_chk #(
  parameter int WIDTH = 1
) (
  input logic             ick,
  input logic             ice,
  input logic             ock,
  input logic             oce,
  input logic             rst,
  input logic             set,
  input logic [WIDTH-1:0] pad_i,
  input logic [WIDTH-1:0] in_rise,
  input logic [WIDTH-1:0] in_fall,
  input logic [WIDTH-1:0] pad_o,
  input logic [WIDTH-1:0] pad_oe
);

  p_capture_rise_r1: assert property (@(posedge ick) disable iff (rst || set)
    ($past(ice) && !$past(rst) && !$past(set)) |-> (in_rise == $past(pad_i)));

  p_in_hold_r5: assert property (@(posedge ick) disable iff (rst || set)
    (!$past(ice) && !$past(rst) && !$past(set)) |-> $stable(in_rise));

  p_out_hold_r6: assert property (@(negedge ock) disable iff (rst || set)
    !oce |-> $stable(pad_o) && $stable(pad_oe));

  // R7 and R9: reset clears everything, even with set high
  p_reset_wins_r9: assert property (@(posedge ick) disable iff (!rst)
    $past(rst) |-> (in_rise == '0 && in_fall == '0 && pad_o == '0 && pad_oe == '0));

  p_set_ones_r8: assert property (@(posedge ick) disable iff (!set || rst)
    ($past(set) && !$past(rst)) |-> (in_rise == '1 && in_fall == '1 && pad_o == '1 && pad_oe == '1));

endmodule

bind ddr_io_cell ddr_io_cell_chk #(.WIDTH(WIDTH)) u_chk (
  .ick(ick), .ice(ice), .ock(ock), .oce(oce), .rst(rst), .set(set),
  .pad_i(pad_i), .in_rise(in_rise), .in_fall(in_fall),
  .pad_o(pad_o), .pad_oe(pad_oe)
);

// File: tb/ddr_io_cell_tb_top.sv
module ddr_io_cell_ref #(
  parameter int WIDTH    = 4,
  parameter bit ASYNC_SR = 1'b1
) (
  input  logic             clk,
  input  logic             ice,
  input  logic             oce,
  input  logic             rst,
  input  logic             set,
  input  logic [WIDTH-1:0] pad_i,
  input  logic [WIDTH-1:0] od_rise,
  input  logic [WIDTH-1:0] od_fall,
  input  logic [WIDTH-1:0] oe_rise,
  input  logic [WIDTH-1:0] oe_fall,
  output logic [WIDTH-1:0] e_in_rise,
  output logic [WIDTH-1:0] e_in_fall,
  output logic [WIDTH-1:0] e_pad_o,
  output logic [WIDTH-1:0] e_pad_oe
);
  logic [WIDTH-1:0] m_ir = 'x, m_if = 'x, m_or = 'x, m_of = 'x, m_er = 'x, m_ef = 'x;
  logic last_clk = 1'b0;

  always @(posedge clk or negedge clk or posedge rst or posedge set) begin
    if (clk !== last_clk) begin
      last_clk = clk;
      if (clk) begin
        if (rst) begin m_ir = '0; m_or = '0; m_er = '0; end
        else if (set) begin m_ir = '1; m_or = '1; m_er = '1; end
        else begin
          if (ice) m_ir = pad_i;
          if (oce) begin m_or = od_rise; m_er = oe_rise; end
        end
      end else begin
        if (rst) begin m_if = '0; m_of = '0; m_ef = '0; end
        else if (set) begin m_if = '1; m_of = '1; m_ef = '1; end
        else begin
          if (ice) m_if = pad_i;
          if (oce) begin m_of = od_fall; m_ef = oe_fall; end
        end
      end
    end else if (ASYNC_SR) begin
      if (rst) begin m_ir = '0; m_if = '0; m_or = '0; m_of = '0; m_er = '0; m_ef = '0; end
      else if (set) begin m_ir = '1; m_if = '1; m_or = '1; m_of = '1; m_er = '1; m_ef = '1; end
    end
  end

  assign e_in_rise = m_ir;
  assign e_in_fall = m_if;
  assign e_pad_o   = clk ? m_or : m_of;
  assign e_pad_oe  = clk ? m_er : m_ef;
endmodule

module ddr_io_cell_tb_top;
  localparam int W = 4;

  logic clk = 1'b0;
  logic ice = 1'b1, oce = 1'b1, rst = 1'b0, set = 1'b0;
  logic [W-1:0] pad_i = '0, od_rise = '0, od_fall = '0, oe_rise = '0, oe_fall = '0;
  logic [W-1:0] a_ir, a_if, a_o, a_oe, s_ir, s_if, s_o, s_oe;
  logic [W-1:0] x_ir, x_if, x_o, x_oe, y_ir, y_if, y_o, y_oe;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ddr_io_cell #(.WIDTH(W), .ASYNC_SR(1'b1)) dut_i (
    .ick(clk), .ice(ice), .ock(clk), .oce(oce), .rst(rst), .set(set),
    .pad_i(pad_i), .od_rise(od_rise), .od_fall(od_fall),
    .oe_rise(oe_rise), .oe_fall(oe_fall),
    .in_rise(a_ir), .in_fall(a_if), .pad_o(a_o), .pad_oe(a_oe));

  ddr_io_cell #(.WIDTH(W), .ASYNC_SR(1'b0)) dut_s (
    .ick(clk), .ice(ice), .ock(clk), .oce(oce), .rst(rst), .set(set),
    .pad_i(pad_i), .od_rise(od_rise), .od_fall(od_fall),
    .oe_rise(oe_rise), .oe_fall(oe_fall),
    .in_rise(s_ir), .in_fall(s_if), .pad_o(s_o), .pad_oe(s_oe));

  ddr_io_cell_ref #(.WIDTH(W), .ASYNC_SR(1'b1)) ref_a (
    .clk(clk), .ice(ice), .oce(oce), .rst(rst), .set(set), .pad_i(pad_i),
    .od_rise(od_rise), .od_fall(od_fall), .oe_rise(oe_rise), .oe_fall(oe_fall),
    .e_in_rise(x_ir), .e_in_fall(x_if), .e_pad_o(x_o), .e_pad_oe(x_oe));

  ddr_io_cell_ref #(.WIDTH(W), .ASYNC_SR(1'b0)) ref_s (
    .clk(clk), .ice(ice), .oce(oce), .rst(rst), .set(set), .pad_i(pad_i),
    .od_rise(od_rise), .od_fall(od_fall), .oe_rise(oe_rise), .oe_fall(oe_fall),
    .e_in_rise(y_ir), .e_in_fall(y_if), .e_pad_o(y_o), .e_pad_oe(y_oe));

  task automatic cmp(input string phase, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (phase %s) %s at %0t: actual %b expected %b", req, phase, what, $time, act, exp);
    end
  endtask

  task automatic check_all(input string phase);
    cmp(phase, "R1", "async in_rise", a_ir, x_ir);
    cmp(phase, "R2", "async in_fall", a_if, x_if);
    cmp(phase, "R3", "async pad_o",   a_o,  x_o);
    cmp(phase, "R4", "async pad_oe",  a_oe, x_oe);
    cmp(phase, "R10", "sync in_rise", s_ir, y_ir);
    cmp(phase, "R10", "sync in_fall", s_if, y_if);
    cmp(phase, "R10", "sync pad_o",   s_o,  y_o);
    cmp(phase, "R10", "sync pad_oe",  s_oe, y_oe);
  endtask

  task automatic new_data();
    pad_i   = W'($urandom);
    od_rise = W'($urandom);
    od_fall = W'($urandom);
    oe_rise = W'($urandom);
    oe_fall = W'($urandom);
  endtask

  // one period: check after each edge, then drive; controls change after the falling edge
  task automatic cycle(input string phase, input logic n_ice, input logic n_oce,
                       input logic n_rst, input logic n_set);
    @(posedge clk); #5;
    check_all(phase);
    new_data();
    @(negedge clk); #5;
    check_all(phase);
    new_data();
    ice = n_ice; oce = n_oce; rst = n_rst; set = n_set;
  endtask

  initial begin
    #1 rst = 1'b1;
    repeat (3) cycle("R7", 1, 1, 1, 0);
    cycle("R7", 1, 1, 0, 0);
    repeat (40) cycle("R1", 1, 1, 0, 0);
    cycle("R2", 0, 1, 0, 0);
    repeat (10) cycle("R5", 0, 1, 0, 0);
    cycle("R5", 1, 0, 0, 0);
    repeat (10) cycle("R6", 1, 0, 0, 0);
    cycle("R6", 1, 1, 0, 0);
    repeat (5) cycle("R3", 1, 1, 0, 0);
    cycle("R3", 1, 1, 0, 1);
    repeat (4) cycle("R8", 1, 1, 0, 1);
    cycle("R8", 1, 1, 1, 1);
    repeat (4) cycle("R9", 1, 1, 1, 1);
    cycle("R9", 1, 1, 0, 1);
    repeat (2) cycle("R8", 1, 1, 0, 1);
    cycle("R8", 1, 1, 0, 0);
    repeat (20) cycle("R4", 1, 1, 0, 0);
    cycle("R4", 1, 1, 1, 0);
    repeat (3) cycle("R10", 1, 1, 1, 0);
    cycle("R10", 1, 1, 0, 0);
    for (int k = 0; k < 80; k++) begin
      logic ni, no;
      ni = 1'($urandom);
      no = 1'($urandom);
      cycle("R5", ni, no, 0, 0);
    end
    cycle("R6", 1, 1, 0, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule